// File: doc/BRIEF.md
# SIMM Configuration Register Port

This block is the byte-wide I/O register front end of a memory controller that serves six SIMM sockets. Static strap inputs give each socket's module size, and from these the block builds two read-only status bytes: one that flags the sockets holding large (32 MB) modules and an active-low byte that flags which sockets are populated. A fixed parity-status byte always reports that no error was seen.

Firmware sizes the memory banks through a single size-programming register. Each write carries a table entry number in its top three bits and a 5-bit end address in its low five bits, and the value lands in an eight-entry end-address table. The whole table is driven out in parallel to the bank decoder. Reads of the same register walk the table through a hidden read index that advances by one per read and wraps after entry 7. Reading the presence byte sends that index back to entry 0, so firmware can restart the walk at any time.

Each access is a one-cycle strobe. A small two-state response machine, with states IDLE and RESPOND, returns read data one cycle after the read strobe. The machine takes transition IDLE→RESPOND or RESPOND→RESPOND on a read strobe, and RESPOND→IDLE or IDLE→IDLE when there is none.

Top module: `simm_cfg_port`

## Requirements
- R1: The port decodes the full 12-bit address. A read strobe on `io_rd` gives `io_rvalid` high for exactly the next cycle, with `io_rdata` holding the byte for the address presented with the strobe. With no read strobe, `io_rvalid` is low in the following cycle.
- R2: Address 0x803 reads the ID byte. Bit n (n = 0..5) is 1 when socket n carries size code 2'b10 (32 MB), and every other bit is 0. Socket n's code is `socket_size[2n+1:2n]`: 2'b00 means empty, 2'b01 means 8 MB, 2'b10 means 32 MB, and 2'b11 is treated as empty.
- R3: Address 0x804 reads the presence byte, which is active low. Bit n (n = 0..5) is 0 when socket n carries code 2'b01 or 2'b10 and 1 otherwise. Bits 7 and 6 always read 1.
- R4: Every read of 0x804 returns the size-register read index to entry 0.
- R5: A read of 0x820 returns the 5-bit end address at the current read index, zero-extended to a byte. The index then advances by one modulo 8.
- R6: A write to 0x820 stores `io_wdata[4:0]` into the entry numbered `io_wdata[7:5]`. The read index is left unchanged. The new value appears on `end_table[5e+4:5e]` (entry e) after the write's clock edge.
- R7: A read of 0x841 always returns 0x01.
- R8: A read of any other address returns 0xFF. A write to any address other than 0x820 changes nothing.
- R9: Reset clears all eight table entries and the read index to 0, drives `io_rvalid` low and drives `io_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 12 | I/O address of the access |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| socket_size | input | 12 | Two-bit size code per socket, socket 0 in bits 1:0 |
| io_rdata | output | 8 | Read data, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read response valid, one cycle after io_rd |
| end_table | output | 40 | Eight 5-bit end-address entries, entry 0 in bits 4:0 |

## Verification
Read data and `io_rvalid` come from registers that load on the strobe's edge, so each result is due exactly one cycle after the read strobe. A table write shows on `end_table` right after the write's edge, and index changes show up only through the next 0x820 read. The bench drives each strobe for one cycle between falling edges and samples at the falling edge that follows. That places every sample half a cycle after the edge that produced the result. It then samples once more to confirm that `io_rvalid` has dropped.

// File: rtl/simm_cfg_pkg.sv
package simm_cfg_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_8M   = 2'b01,
        SZ_32M  = 2'b10,
        SZ_RSVD = 2'b11
    } simm_size_e;

    typedef enum logic [2:0] {
        SEL_ID,
        SEL_PRES,
        SEL_SIZE,
        SEL_PAR,
        SEL_MISS
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

    localparam int ADDR_ID   = 32'h803;
    localparam int ADDR_PRES = 32'h804;
    localparam int ADDR_SIZE = 32'h820;
    localparam int ADDR_PAR  = 32'h841;

    localparam logic [7:0] PAR_OK_BYTE = 8'h01;
    localparam logic [7:0] MISS_BYTE   = 8'hFF;

endpackage

// File: rtl/simm_socket_status.sv
module simm_socket_status
    import simm_cfg_pkg::*;
#(
    parameter int NUM_SOCKETS = 6,
    parameter int BYTE_W      = 8
) (
    input  logic [2*NUM_SOCKETS-1:0] socket_size,
    output logic [BYTE_W-1:0]        id_byte,
    output logic [BYTE_W-1:0]        pres_byte
);

    for (genvar s = 0; s < BYTE_W; s++) begin : g_bit
        if (s < NUM_SOCKETS) begin : g_sock
            simm_size_e code;
            assign code         = simm_size_e'(socket_size[2*s +: 2]);
            assign id_byte[s]   = (code == SZ_32M);
            assign pres_byte[s] = !((code == SZ_8M) || (code == SZ_32M));
        end else begin : g_pad
            assign id_byte[s]   = 1'b0;
            assign pres_byte[s] = 1'b1;
        end
    end

endmodule

// File: rtl/simm_end_table.sv
module simm_end_table #(
    parameter int NUM_ENTRIES = 8,
    parameter int END_W       = 5,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [END_W-1:0]             wr_val,
    input  logic                         rd_step,
    input  logic                         idx_clear,
    output logic [END_W-1:0]             cur_entry,
    output logic [NUM_ENTRIES*END_W-1:0] table_flat
);

    logic [END_W-1:0] entry_q [NUM_ENTRIES];
    logic [IDX_W-1:0] idx_q;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                entry_q[e] <= wr_val;
            end
        end
        assign table_flat[e*END_W +: END_W] = entry_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clear) begin
            idx_q <= '0;
        end else if (rd_step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_entry = entry_q[idx_q];

    assert_idx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clear |=> (idx_q == '0));

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !idx_clear) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    assert_wr_keeps_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_step && !idx_clear) |=> $stable(idx_q));

endmodule

// File: rtl/simm_cfg_port.sv
module simm_cfg_port
    import simm_cfg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_SOCKETS = 6,
    parameter int NUM_ENTRIES = 8,
    parameter int END_W       = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            io_addr,
    input  logic                         io_rd,
    input  logic                         io_wr,
    input  logic [7:0]                   io_wdata,
    input  logic [2*NUM_SOCKETS-1:0]     socket_size,
    output logic [7:0]                   io_rdata,
    output logic                         io_rvalid,
    output logic [NUM_ENTRIES*END_W-1:0] end_table
);

    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] SOCK_MASK = DATA_W'((1 << NUM_SOCKETS) - 1);

    reg_sel_e          sel;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] pres_byte;
    logic [END_W-1:0]  cur_entry;
    logic [DATA_W-1:0] rd_mux;
    port_state_e       state_q;
    port_state_e       state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        if (io_addr == ADDR_W'(ADDR_ID))        sel = SEL_ID;
        else if (io_addr == ADDR_W'(ADDR_PRES)) sel = SEL_PRES;
        else if (io_addr == ADDR_W'(ADDR_SIZE)) sel = SEL_SIZE;
        else if (io_addr == ADDR_W'(ADDR_PAR))  sel = SEL_PAR;
        else                                    sel = SEL_MISS;
    end

    simm_socket_status #(
        .NUM_SOCKETS (NUM_SOCKETS),
        .BYTE_W      (DATA_W)
    ) u_status (
        .socket_size (socket_size),
        .id_byte     (id_byte),
        .pres_byte   (pres_byte)
    );

    simm_end_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .END_W       (END_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (io_wr && (sel == SEL_SIZE)),
        .wr_idx     (io_wdata[END_W +: IDX_W]),
        .wr_val     (io_wdata[END_W-1:0]),
        .rd_step    (io_rd && (sel == SEL_SIZE)),
        .idx_clear  (io_rd && (sel == SEL_PRES)),
        .cur_entry  (cur_entry),
        .table_flat (end_table)
    );

    always_comb begin
        unique case (sel)
            SEL_ID:   rd_mux = id_byte;
            SEL_PRES: rd_mux = pres_byte;
            SEL_SIZE: rd_mux = DATA_W'(cur_entry);
            SEL_PAR:  rd_mux = PAR_OK_BYTE;
            default:  rd_mux = MISS_BYTE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = io_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = io_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (io_rd) rdata_q <= rd_mux;
        else            rdata_q <= '0;
    end

    assign io_rvalid = (state_q == ST_RESP);
    assign io_rdata  = rdata_q;

    assert_valid_after_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> io_rvalid);

    assert_idle_without_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);

    assert_pres_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (sel == SEL_PRES)) |=> ((io_rdata | SOCK_MASK) == 8'hFF));

    assert_parity_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (sel == SEL_PAR)) |=> (io_rdata == PAR_OK_BYTE));

    assert_miss_reads_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (sel == SEL_MISS)) |=> (io_rdata == MISS_BYTE));

endmodule

// File: tb/simm_cfg_port_test.sv
module simm_cfg_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [11:0] socket_size = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [39:0] end_table;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [4:0]  model [8];
    logic [7:0]  got;
    logic [39:0] snap;

    always #5 clk = ~clk;

    simm_cfg_port uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_addr     (io_addr),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_wdata    (io_wdata),
        .socket_size (socket_size),
        .io_rdata    (io_rdata),
        .io_rvalid   (io_rvalid),
        .end_table   (end_table)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(io_rvalid == 1'b1, "R1 rvalid", 64'(io_rvalid), 64'd1);
        d = io_rdata;
        @(negedge clk);
        check(io_rvalid == 1'b0, "R1 rvalid drop", 64'(io_rvalid), 64'd0);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    function automatic logic [39:0] model_flat();
        logic [39:0] f;
        for (int e = 0; e < 8; e++) f[e*5 +: 5] = model[e];
        return f;
    endfunction

    initial begin
        for (int e = 0; e < 8; e++) model[e] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(io_rvalid == 1'b0, "R9 rvalid", 64'(io_rvalid), 64'd0);
        check(io_rdata == 8'h00, "R9 rdata", 64'(io_rdata), 64'd0);
        check(end_table == '0, "R9 table", 64'(end_table), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(end_table == '0, "R9 table after release", 64'(end_table), 64'd0);
        do_read(12'h820, got);
        check(got == 8'h00, "R9 entry0 read", 64'(got), 64'd0);

        // R2 / R3: every combination of socket codes
        for (int c = 0; c < 4096; c++) begin
            logic [7:0] exp_id;
            logic [7:0] exp_pr;
            socket_size = 12'(c);
            exp_id = 8'h00;
            exp_pr = 8'hFF;
            for (int s = 0; s < 6; s++) begin
                int code;
                code = (c >> (2 * s)) % 4;
                if (code == 2) exp_id[s] = 1'b1;
                if (code == 1 || code == 2) exp_pr[s] = 1'b0;
            end
            do_read(12'h803, got);
            check(got == exp_id, "R2 id byte", 64'(got), 64'(exp_id));
            do_read(12'h804, got);
            check(got == exp_pr, "R3 presence byte", 64'(got), 64'(exp_pr));
        end

        // R6: program every entry
        for (int e = 0; e < 8; e++) begin
            model[e] = 5'((e * 7 + 3) % 32);
            do_write(12'h820, {3'(e), model[e]});
            check(end_table == model_flat(), "R6 table write", 64'(end_table),
                  64'(model_flat()));
        end

        // R4 / R5: walk and wrap
        do_read(12'h804, got);
        for (int i = 0; i < 11; i++) begin
            do_read(12'h820, got);
            check(got == {3'b000, model[i % 8]}, "R5 walk", 64'(got), 64'(model[i % 8]));
        end

        // R6: write mid-walk does not move index
        do_read(12'h804, got);
        for (int i = 0; i < 3; i++) do_read(12'h820, got);
        model[5] = 5'h1F;
        do_write(12'h820, {3'd5, 5'h1F});
        check(end_table == model_flat(), "R6 entry5 rewrite", 64'(end_table),
              64'(model_flat()));
        for (int i = 3; i < 6; i++) begin
            do_read(12'h820, got);
            check(got == {3'b000, model[i]}, "R6 index untouched", 64'(got), 64'(model[i]));
        end

        // R4: presence read restarts walk
        do_read(12'h804, got);
        do_read(12'h820, got);
        check(got == {3'b000, model[0]}, "R4 index cleared", 64'(got), 64'(model[0]));

        // R7: parity byte
        for (int i = 0; i < 3; i++) begin
            do_read(12'h841, got);
            check(got == 8'h01, "R7 parity", 64'(got), 64'h01);
        end

        // R8: unmapped addresses
        do_read(12'h805, got);
        check(got == 8'hFF, "R8 read 805", 64'(got), 64'hFF);
        do_read(12'hC41, got);
        check(got == 8'hFF, "R8 read C41", 64'(got), 64'hFF);
        do_read(12'h000, got);
        check(got == 8'hFF, "R8 read 000", 64'(got), 64'hFF);
        snap = end_table;
        do_write(12'h821, 8'h00);
        check(end_table == snap, "R8 write 821 ignored", 64'(end_table), 64'(snap));
        do_write(12'h803, 8'h20);
        check(end_table == snap, "R8 write 803 ignored", 64'(end_table), 64'(snap));
        do_write(12'h804, 8'hE0);
        check(end_table == snap, "R8 write 804 ignored", 64'(end_table), 64'(snap));
        do_read(12'h820, got);
        check(got == {3'b000, model[1]}, "R8 writes left index", 64'(got), 64'(model[1]));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule